// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits between the per-channel conversion data path of a multi-channel ADC and its serial output stage. In normal operation it passes each channel's sample word to the output register. When a pattern mode is enabled, a synthetic word replaces the live data on every channel, so that a downstream receiver can find word boundaries and align its links. Five patterns are available: a counting ramp, a constant programmable code, two programmable codes in alternation, a fixed alternating-bit word for deskew, and a fixed framing word for sync.

Each word is 14 bits wide. In 12-bit resolution mode a word keeps only its upper 12 bits and is right-justified, with bits 13:12 at zero. The ramp is the exception: it counts directly in the 12-bit range. The bit-order request for the serializer is registered alongside the data. Patterns therefore reach the serializer with the same ordering control as live samples. All outputs are registered and appear one clock after the edge that samples their inputs.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: While rst_ni is low, every data_o word is 0 and lsb_first_o is 0.
- R2: With no pattern enabled, each channel's output word equals that channel's sample word from the previous edge in 14-bit mode (res12_i=0), or that sample shifted right by two in 12-bit mode (res12_i=1).
- R3: In ramp mode the first word after ramp_en_i rises is 0, and each later word is one more than the previous one. The same value is driven on all channels.
- R4: The ramp wraps from 16383 to 0 in 14-bit mode and from 4095 to 0 in 12-bit mode.
- R5: In single-code mode every channel outputs code_a_i, or code_a_i shifted right by two in 12-bit mode.
- R6: In dual-code mode the first word after the mode is selected is code A. The output then alternates B, A, B, ... on every clock, with the same 12-bit narrowing as R5.
- R7: In deskew mode every channel outputs 14'h1555 (01010101010101b), or 12'h555 in 12-bit mode.
- R8: In sync mode every channel outputs 14'h1F80 (1111110000000b), or 14'h07E0 in 12-bit mode.
- R9: If several enables are set together, the selection order is ramp, then dual, then single, then deskew, then sync.
- R10: lsb_first_o equals lsb_first_i from the previous edge, whatever mode is active.
- R11: While any pattern is active, the sample inputs have no effect on data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res12_i | input | 1 | 1 selects 12-bit resolution, 0 selects 14-bit |
| lsb_first_i | input | 1 | Bit-order request passed to the serializer |
| ramp_en_i | input | 1 | Ramp pattern enable |
| dual_en_i | input | 1 | Alternating two-code pattern enable |
| single_en_i | input | 1 | Constant code pattern enable |
| deskew_en_i | input | 1 | Alternating-bit deskew word enable |
| sync_en_i | input | 1 | Framing sync word enable |
| code_a_i | input | 14 | Programmable code A, bit 0 is the LSB |
| code_b_i | input | 14 | Programmable code B, bit 0 is the LSB |
| sample_i | input | NUM_CH*14 | Live sample words, channel c at bits [14c+13:14c] |
| data_o | output | NUM_CH*14 | Output words, same packing as sample_i |
| lsb_first_o | output | 1 | Registered bit-order flag |

## Verification
Two functions can fall in the same cycle: several pattern enables raised together, and the hand-over from one source to the next when the higher-priority enable drops. The bench sets all five enables at once and then clears them one per cycle, from highest priority to lowest. Each intermediate word must come from the expected source. The dual sequence must restart on code A, because it was not selected while the ramp held priority. A second overlap is live sample changes while a pattern is active; the bench requires the pattern word to stay unchanged.

// File: rtl/adc_tpg_pkg.sv
package adc_tpg_pkg;
  localparam int unsigned WORD_W = 14;
  localparam int unsigned NARROW_SHIFT = 2;
  localparam logic [WORD_W-1:0] DESKEW_WORD = 14'h1555;
  localparam logic [WORD_W-1:0] SYNC_WORD   = 14'h1F80;
  localparam logic [WORD_W-1:0] FS_WIDE     = 14'h3FFF;
  localparam logic [WORD_W-1:0] FS_NARROW   = 14'h0FFF;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    SRC_LIVE,
    SRC_RAMP,
    SRC_DUAL,
    SRC_SINGLE,
    SRC_DESKEW,
    SRC_SYNC
  } src_e;

  // 12-bit mode keeps the upper bits, right-justified
  function automatic word_t fit_word(word_t w, logic res12);
    return res12 ? (w >> NARROW_SHIFT) : w;
  endfunction
endpackage

// File: rtl/adc_tpg_prio.sv
module adc_tpg_prio
  import adc_tpg_pkg::*;
(
  input  logic ramp_en_i,
  input  logic dual_en_i,
  input  logic single_en_i,
  input  logic deskew_en_i,
  input  logic sync_en_i,
  output src_e src_o
);
  always_comb begin
    if (ramp_en_i)        src_o = SRC_RAMP;
    else if (dual_en_i)   src_o = SRC_DUAL;
    else if (single_en_i) src_o = SRC_SINGLE;
    else if (deskew_en_i) src_o = SRC_DESKEW;
    else if (sync_en_i)   src_o = SRC_SYNC;
    else                  src_o = SRC_LIVE;
  end
endmodule

// File: rtl/adc_tpg_ramp.sv
module adc_tpg_ramp
  import adc_tpg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  res12_i,
  output word_t cnt_o
);
  word_t cnt_q;
  word_t fs;

  assign fs    = res12_i ? FS_NARROW : FS_WIDE;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q >= fs) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_tpg_dual.sv
module adc_tpg_dual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic use_b_o
);
  logic phase_q;

  assign use_b_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= 1'b0;
    else if (!sel_i) phase_q <= 1'b0;
    else             phase_q <= ~phase_q;
  end
endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
  import adc_tpg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned BUS_W = NUM_CH * WORD_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    res12_i,
  input  logic                    lsb_first_i,
  input  logic                    ramp_en_i,
  input  logic                    dual_en_i,
  input  logic                    single_en_i,
  input  logic                    deskew_en_i,
  input  logic                    sync_en_i,
  input  logic [WORD_W-1:0]       code_a_i,
  input  logic [WORD_W-1:0]       code_b_i,
  input  logic [BUS_W-1:0]        sample_i,
  output logic [BUS_W-1:0]        data_o,
  output logic                    lsb_first_o
);
  src_e  src;
  word_t ramp_cnt;
  logic  use_b;
  word_t pat_word;

  adc_tpg_prio u_prio (
    .ramp_en_i   (ramp_en_i),
    .dual_en_i   (dual_en_i),
    .single_en_i (single_en_i),
    .deskew_en_i (deskew_en_i),
    .sync_en_i   (sync_en_i),
    .src_o       (src)
  );

  adc_tpg_ramp u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (src == SRC_RAMP),
    .res12_i (res12_i),
    .cnt_o   (ramp_cnt)
  );

  adc_tpg_dual u_dual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (src == SRC_DUAL),
    .use_b_o (use_b)
  );

  always_comb begin
    unique case (src)
      SRC_RAMP:   pat_word = res12_i ? (ramp_cnt & FS_NARROW) : ramp_cnt;
      SRC_DUAL:   pat_word = fit_word(use_b ? code_b_i : code_a_i, res12_i);
      SRC_SINGLE: pat_word = fit_word(code_a_i, res12_i);
      SRC_DESKEW: pat_word = fit_word(DESKEW_WORD, res12_i);
      SRC_SYNC:   pat_word = fit_word(SYNC_WORD, res12_i);
      default:    pat_word = '0;
    endcase
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    word_t word_d, word_q;
    assign word_d = (src == SRC_LIVE) ? fit_word(sample_i[c*WORD_W +: WORD_W], res12_i)
                                      : pat_word;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else         word_q <= word_d;
    end
    assign data_o[c*WORD_W +: WORD_W] = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lsb_first_o <= 1'b0;
    else         lsb_first_o <= lsb_first_i;
  end
endmodule

// File: rtl/adc_tpg_chk.sv
module adc_tpg_chk
  import adc_tpg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       res12_i,
  input logic                       lsb_first_i,
  input logic                       ramp_en_i,
  input logic                       dual_en_i,
  input logic                       single_en_i,
  input logic                       deskew_en_i,
  input logic                       sync_en_i,
  input logic [WORD_W-1:0]          code_a_i,
  input logic [WORD_W-1:0]          code_b_i,
  input logic [NUM_CH*WORD_W-1:0]   sample_i,
  input logic [NUM_CH*WORD_W-1:0]   data_o,
  input logic                       lsb_first_o
);
  logic  none_en, dual_act, single_act, deskew_act;
  logic  prev_ramp_q, prev_dual_q, prev_res_q;
  word_t prev_a_q, prev_b_q;
  word_t ch0;

  assign ch0        = data_o[WORD_W-1:0];
  assign none_en    = !(ramp_en_i || dual_en_i || single_en_i || deskew_en_i || sync_en_i);
  assign dual_act   = dual_en_i && !ramp_en_i;
  assign single_act = single_en_i && !ramp_en_i && !dual_en_i;
  assign deskew_act = deskew_en_i && !ramp_en_i && !dual_en_i && !single_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ramp_q <= 1'b0;
      prev_dual_q <= 1'b0;
      prev_res_q  <= 1'b0;
      prev_a_q    <= '0;
      prev_b_q    <= '0;
    end else begin
      prev_ramp_q <= ramp_en_i;
      prev_dual_q <= dual_act;
      prev_res_q  <= res12_i;
      prev_a_q    <= code_a_i;
      prev_b_q    <= code_b_i;
    end
  end

  // R2
  live_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (none_en && !res12_i) |=> ch0 == $past(sample_i[WORD_W-1:0]));

  // R3
  ramp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_ramp_q && ramp_en_i && !res12_i && !prev_res_q)
      |=> ch0 == word_t'($past(ch0) + 1'b1));

  // R5
  single_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_act && !res12_i) |=> ch0 == $past(code_a_i));

  // R6
  dual_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_act && prev_dual_q && !res12_i && !prev_res_q && code_a_i != code_b_i
     && code_a_i == prev_a_q && code_b_i == prev_b_q)
      |=> ch0 == (($past(ch0) == $past(code_a_i)) ? $past(code_b_i) : $past(code_a_i)));

  // R7
  deskew_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deskew_act && !res12_i) |=> ch0 == 14'h1555);

  // R10
  order_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> lsb_first_o == $past(lsb_first_i));
endmodule

bind adc_test_pattern_gen adc_tpg_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res12_i     (res12_i),
  .lsb_first_i (lsb_first_i),
  .ramp_en_i   (ramp_en_i),
  .dual_en_i   (dual_en_i),
  .single_en_i (single_en_i),
  .deskew_en_i (deskew_en_i),
  .sync_en_i   (sync_en_i),
  .code_a_i    (code_a_i),
  .code_b_i    (code_b_i),
  .sample_i    (sample_i),
  .data_o      (data_o),
  .lsb_first_o (lsb_first_o)
);

// File: tb/adc_test_pattern_gen_tb.sv
module adc_test_pattern_gen_tb_top;
  localparam int NCH = 8;
  localparam int W   = 14;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic res12_i = 1'b0, lsb_first_i = 1'b0;
  logic ramp_en_i = 1'b0, dual_en_i = 1'b0, single_en_i = 1'b0;
  logic deskew_en_i = 1'b0, sync_en_i = 1'b0;
  logic [W-1:0] code_a_i = '0, code_b_i = '0;
  logic [NCH*W-1:0] sample_i = '0;
  logic [NCH*W-1:0] data_o;
  logic lsb_first_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  adc_test_pattern_gen #(.NUM_CH(NCH)) dut_i (.*);

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // every channel must carry exp
  task automatic chk_all(string req, logic [W-1:0] exp);
    checks++;
    for (int c = 0; c < NCH; c++) begin
      if (data_o[c*W +: W] !== exp) begin
        failures++;
        $display("FAIL %s: ch%0d actual=%h expected=%h", req, c, data_o[c*W +: W], exp);
        break;
      end
    end
  endtask

  task automatic clear_modes();
    ramp_en_i = 0; dual_en_i = 0; single_en_i = 0; deskew_en_i = 0; sync_en_i = 0;
  endtask

  task automatic load_samples(int seed);
    for (int c = 0; c < NCH; c++) sample_i[c*W +: W] = W'(seed * 977 + c * 1311 + 5);
  endtask

  task automatic t_reset();
    chk_all("R1 reset data", '0);
    chk_bit("R1 reset flag", lsb_first_o, 1'b0);
  endtask

  task automatic t_live();
    for (int r = 0; r < 2; r++) begin
      @(negedge clk_i); clear_modes(); res12_i = r[0]; load_samples(r + 3);
      @(negedge clk_i);
      checks++;
      for (int c = 0; c < NCH; c++) begin
        logic [W-1:0] e = r[0] ? (sample_i[c*W +: W] >> 2) : sample_i[c*W +: W];
        if (data_o[c*W +: W] !== e) begin
          failures++;
          $display("FAIL R2 live ch%0d: actual=%h expected=%h", c, data_o[c*W +: W], e);
        end
      end
    end
  endtask

  task automatic t_ramp(logic narrow, int len);
    int fs = narrow ? 4096 : 16384;
    @(negedge clk_i); clear_modes(); res12_i = narrow;
    @(negedge clk_i); ramp_en_i = 1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk_i);
      if (k < fs) chk_all("R3 ramp step", W'(k % fs));
      else        chk_all("R4 ramp wrap", W'(k % fs));
    end
    // restart from zero after a gap
    ramp_en_i = 0;
    @(negedge clk_i); ramp_en_i = 1;
    @(negedge clk_i); chk_all("R3 ramp restart", '0);
    @(negedge clk_i); chk_all("R3 ramp restart+1", 14'd1);
    ramp_en_i = 0;
  endtask

  task automatic t_single();
    @(negedge clk_i); clear_modes(); res12_i = 0; code_a_i = 14'h2A5C; single_en_i = 1;
    @(negedge clk_i); chk_all("R5 single 14b", 14'h2A5C);
    load_samples(9);
    @(negedge clk_i); chk_all("R11 samples ignored", 14'h2A5C);
    res12_i = 1;
    @(negedge clk_i); chk_all("R5 single 12b", 14'h0A97);
  endtask

  task automatic t_dual();
    @(negedge clk_i); clear_modes(); res12_i = 0;
    code_a_i = 14'h2A5C; code_b_i = 14'h1234; dual_en_i = 1;
    @(negedge clk_i); chk_all("R6 dual first A", 14'h2A5C);
    @(negedge clk_i); chk_all("R6 dual B", 14'h1234);
    @(negedge clk_i); chk_all("R6 dual A", 14'h2A5C);
    res12_i = 1;
    @(negedge clk_i); chk_all("R6 dual B 12b", 14'h048D);
    dual_en_i = 0; res12_i = 0;
    @(negedge clk_i); dual_en_i = 1;
    @(negedge clk_i); chk_all("R6 dual restart A", 14'h2A5C);
  endtask

  task automatic t_fixed();
    @(negedge clk_i); clear_modes(); res12_i = 0; deskew_en_i = 1;
    @(negedge clk_i); chk_all("R7 deskew 14b", 14'h1555);
    res12_i = 1;
    @(negedge clk_i); chk_all("R7 deskew 12b", 14'h0555);
    clear_modes(); sync_en_i = 1;
    @(negedge clk_i); chk_all("R8 sync 12b", 14'h07E0);
    res12_i = 0;
    @(negedge clk_i); chk_all("R8 sync 14b", 14'h1F80);
  endtask

  task automatic t_priority();
    @(negedge clk_i); res12_i = 0; code_a_i = 14'h0F0F; code_b_i = 14'h3003;
    ramp_en_i = 1; dual_en_i = 1; single_en_i = 1; deskew_en_i = 1; sync_en_i = 1;
    @(negedge clk_i); chk_all("R9 ramp wins", '0);
    ramp_en_i = 0;
    @(negedge clk_i); chk_all("R9 dual next", 14'h0F0F);
    dual_en_i = 0;
    @(negedge clk_i); chk_all("R9 single next", 14'h0F0F);
    code_a_i = 14'h0123;
    @(negedge clk_i); chk_all("R9 single follows code", 14'h0123);
    single_en_i = 0;
    @(negedge clk_i); chk_all("R9 deskew next", 14'h1555);
    deskew_en_i = 0;
    @(negedge clk_i); chk_all("R9 sync last", 14'h1F80);
    sync_en_i = 0;
  endtask

  task automatic t_order();
    @(negedge clk_i); clear_modes(); lsb_first_i = 1;
    @(negedge clk_i); chk_bit("R10 flag live", lsb_first_o, 1'b1);
    sync_en_i = 1; lsb_first_i = 0;
    @(negedge clk_i); chk_bit("R10 flag pattern", lsb_first_o, 1'b0);
    lsb_first_i = 1;
    @(negedge clk_i); chk_bit("R10 flag pattern set", lsb_first_o, 1'b1);
    clear_modes();
  endtask

  initial begin
    load_samples(1);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_live();
    t_ramp(1'b0, 16390);
    t_ramp(1'b1, 4100);
    t_single();
    t_dual();
    t_fixed();
    t_priority();
    t_order();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule